// File: doc/BRIEF.md
# Dynamic thread boundary selector

This block sits beside the retire-order instruction stream of a speculative multiprocessor and chooses where one speculative thread stops and the next one starts. Each cycle it may take one dynamic instruction, described by a valid flag, its PC and two flags that mark it as a load or a store. When it decides to cut, it raises a one-cycle pulse. With that pulse it reports the PC of the instruction that opens the new thread and the number of instructions in the thread that just closed.

In memory-slice mode a new thread first runs through a minimum skip region, and no cut is placed inside it. After that region the block cuts just ahead of the first load or store it sees. If no memory access turns up, it cuts at a hard maximum length. In fixed-interval mode the instruction type is ignored and every thread holds exactly the programmed interval.

A flush abandons the thread in progress and restarts counting from a supplied PC. A stall freezes the block. Configuration is loaded through a simple write strobe.

Top module: `thread_cut_unit`

## Requirements
- R1: After reset `cutPulse` and `cutLength` are 0 and the thread count is 0. The configuration defaults are skip distance 16, maximum length 64, interval 16 and memory-slice mode.
- R2: In memory-slice mode, an instruction that arrives while the current thread holds fewer than skip-distance instructions never causes a cut, even when it is a load or a store.
- R3: In memory-slice mode, a load or store (either flag set, or both) that arrives while the thread holds at least skip-distance instructions closes the thread just before itself. One cycle after that instruction is accepted, `cutPulse` is 1, `cutStartPc` equals its PC and `cutLength` equals the count before it. The new thread then holds 1 instruction.
- R4: In memory-slice mode, an instruction that arrives while the thread already holds the maximum length causes a cut before itself. It is reported as in R3, with `cutLength` equal to the maximum length.
- R5: When the programmed maximum length is below the skip distance, the skip distance is used as the maximum length.
- R6: In fixed-interval mode (`cfgMemMode` = 0) load and store flags are ignored. An instruction that arrives while the thread holds the interval count causes a cut, so every thread holds exactly the interval.
- R7: An instruction that is both a memory-slice candidate and the maximum-length point produces exactly one cut pulse.
- R8: A cycle with `instValid` low and no flush produces no pulse on the next cycle and does not change the thread count.
- R9: While `stall` is high and `flush` is low, instructions are not accepted, counts are frozen, the next cycle shows no pulse, and the reported PC and length hold.
- R10: A flush, which overrides stall, gives a pulse on the next cycle with `cutStartPc` equal to `flushPc` and `cutLength` 0. It clears the thread count, so a full skip region is again required.
- R11: A configuration write takes effect for instructions accepted from the cycle after the write. An instruction accepted in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load the four configuration fields |
| cfgSkip | input | LEN_W | Skip distance |
| cfgMaxLen | input | LEN_W | Maximum thread length in memory-slice mode |
| cfgInterval | input | LEN_W | Thread length in fixed-interval mode |
| cfgMemMode | input | 1 | 1 = memory-slice mode, 0 = fixed-interval mode |
| instValid | input | 1 | An instruction is presented this cycle |
| instPc | input | PC_W | PC of the presented instruction |
| instIsLoad | input | 1 | Presented instruction is a load |
| instIsStore | input | 1 | Presented instruction is a store |
| stall | input | 1 | Freeze the block |
| flush | input | 1 | Abandon the current thread |
| flushPc | input | PC_W | PC at which counting restarts after a flush |
| cutPulse | output | 1 | One-cycle boundary report |
| cutStartPc | output | PC_W | First PC of the new thread |
| cutLength | output | LEN_W | Instruction count of the closed thread |

## Verification
Two kinds of cut can fall on the same instruction: a memory-slice candidate and the maximum-length point. This is provoked by setting the maximum length equal to the skip distance and presenting a load exactly when the thread reaches that count. It is judged correct only if the bench sees one pulse carrying that count, followed by a quiet cycle on the next plain instruction. A second coincidence, flush and stall raised together, must produce the flush report, not the frozen state.

// File: rtl/thread_cut_pkg.sv
package thread_cut_pkg;

  // Strobes passed from the decision logic to the datapath each cycle.
  typedef struct packed {
    logic restart;  // flush: begin a fresh thread at the flush PC
    logic hold;     // stall: freeze everything
    logic accept;   // an instruction is taken into the current thread
    logic cut;      // accepted instruction opens a new thread
  } cut_strobe_t;

endpackage

// File: rtl/thread_cut_ctrl.sv
module thread_cut_ctrl
  import thread_cut_pkg::*;
#(
  parameter int LEN_W        = 8,
  parameter int DEF_SKIP     = 16,
  parameter int DEF_MAX      = 64,
  parameter int DEF_INTERVAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [LEN_W-1:0] cfgSkip,
  input  logic [LEN_W-1:0] cfgMaxLen,
  input  logic [LEN_W-1:0] cfgInterval,
  input  logic             cfgMemMode,
  input  logic             instValid,
  input  logic             instIsLoad,
  input  logic             instIsStore,
  input  logic             stall,
  input  logic             flush,
  input  logic [LEN_W-1:0] curLen,
  output cut_strobe_t      strobe
);

  localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);
  localparam logic [LEN_W-1:0] RST_SKIP  = LEN_W'(DEF_SKIP);
  localparam logic [LEN_W-1:0] RST_MAX   = LEN_W'(DEF_MAX);
  localparam logic [LEN_W-1:0] RST_INTVL = LEN_W'(DEF_INTERVAL);

  logic [LEN_W-1:0] skipQ, maxQ, intervalQ;
  logic             memModeQ;

  // Configuration registers; new values apply from the next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skipQ     <= RST_SKIP;
      maxQ      <= RST_MAX;
      intervalQ <= RST_INTVL;
      memModeQ  <= 1'b1;
    end else if (cfgWe) begin
      skipQ     <= cfgSkip;
      maxQ      <= cfgMaxLen;
      intervalQ <= cfgInterval;
      memModeQ  <= cfgMemMode;
    end
  end

  logic [LEN_W-1:0] skipEff, maxEff, intervalEff;
  logic             isMem, memHit, limitHit, accept;

  always_comb begin
    skipEff     = (skipQ == '0) ? ONE : skipQ;
    maxEff      = (maxQ < skipEff) ? skipEff : maxQ;
    intervalEff = (intervalQ == '0) ? ONE : intervalQ;
    isMem       = instIsLoad | instIsStore;
    accept      = instValid & ~stall & ~flush;
    memHit      = memModeQ & isMem & (curLen >= skipEff);
    limitHit    = memModeQ ? (curLen >= maxEff) : (curLen >= intervalEff);
  end

  always_comb begin
    strobe.restart = flush;
    strobe.hold    = stall & ~flush;
    strobe.accept  = accept;
    strobe.cut     = accept & (memHit | limitHit);
  end

endmodule

// File: rtl/thread_cut_dp.sv
module thread_cut_dp
  import thread_cut_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cut_strobe_t      strobe,
  input  logic [PC_W-1:0]  instPc,
  input  logic [PC_W-1:0]  flushPc,
  output logic [LEN_W-1:0] curLen,
  output logic             cutPulse,
  output logic [PC_W-1:0]  cutStartPc,
  output logic [LEN_W-1:0] cutLength
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curLen     <= '0;
      cutPulse   <= 1'b0;
      cutStartPc <= '0;
      cutLength  <= '0;
    end else if (strobe.restart) begin
      curLen     <= '0;
      cutPulse   <= 1'b1;
      cutStartPc <= flushPc;
      cutLength  <= '0;
    end else if (strobe.hold) begin
      cutPulse   <= 1'b0;
    end else if (strobe.cut) begin
      curLen     <= ONE;
      cutPulse   <= 1'b1;
      cutStartPc <= instPc;
      cutLength  <= curLen;
    end else begin
      cutPulse   <= 1'b0;
      if (strobe.accept) curLen <= curLen + ONE;
    end
  end

endmodule

// File: rtl/thread_cut_unit.sv
module thread_cut_unit
  import thread_cut_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int LEN_W        = 8,
  parameter int DEF_SKIP     = 16,
  parameter int DEF_MAX      = 64,
  parameter int DEF_INTERVAL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [LEN_W-1:0] cfgSkip,
  input  logic [LEN_W-1:0] cfgMaxLen,
  input  logic [LEN_W-1:0] cfgInterval,
  input  logic             cfgMemMode,
  input  logic             instValid,
  input  logic [PC_W-1:0]  instPc,
  input  logic             instIsLoad,
  input  logic             instIsStore,
  input  logic             stall,
  input  logic             flush,
  input  logic [PC_W-1:0]  flushPc,
  output logic             cutPulse,
  output logic [PC_W-1:0]  cutStartPc,
  output logic [LEN_W-1:0] cutLength
);

  cut_strobe_t      strobe;
  logic [LEN_W-1:0] curLen;

  thread_cut_ctrl #(
    .LEN_W(LEN_W), .DEF_SKIP(DEF_SKIP), .DEF_MAX(DEF_MAX), .DEF_INTERVAL(DEF_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWe(cfgWe), .cfgSkip(cfgSkip), .cfgMaxLen(cfgMaxLen),
    .cfgInterval(cfgInterval), .cfgMemMode(cfgMemMode),
    .instValid(instValid), .instIsLoad(instIsLoad), .instIsStore(instIsStore),
    .stall(stall), .flush(flush), .curLen(curLen), .strobe(strobe)
  );

  thread_cut_dp #(.PC_W(PC_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .instPc(instPc), .flushPc(flushPc), .curLen(curLen),
    .cutPulse(cutPulse), .cutStartPc(cutStartPc), .cutLength(cutLength)
  );

endmodule

// File: rtl/thread_cut_chk.sv
module thread_cut_chk #(
  parameter int PC_W  = 32,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instValid,
  input logic [PC_W-1:0]  instPc,
  input logic             stall,
  input logic             flush,
  input logic [PC_W-1:0]  flushPc,
  input logic             cutPulse,
  input logic [PC_W-1:0]  cutStartPc,
  input logic [LEN_W-1:0] cutLength
);

  p_flush_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cutPulse && cutLength == '0 && cutStartPc == $past(flushPc)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!instValid && !flush) |=> !cutPulse);

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> (!cutPulse && $stable(cutStartPc) && $stable(cutLength)));

  p_start_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cutPulse && !$past(flush)) |-> (cutStartPc == $past(instPc)));

  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cutPulse && !$past(flush)) |-> (cutLength != '0));

endmodule

bind thread_cut_unit thread_cut_chk #(.PC_W(PC_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instValid(instValid), .instPc(instPc),
  .stall(stall), .flush(flush), .flushPc(flushPc), .cutPulse(cutPulse),
  .cutStartPc(cutStartPc), .cutLength(cutLength)
);

// File: tb/thread_cut_unit_bench.sv
`timescale 1ns/1ps
module thread_cut_unit_bench;

  localparam int PC_W  = 32;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfgWe = 1'b0;
  logic [LEN_W-1:0] cfgSkip = '0, cfgMaxLen = '0, cfgInterval = '0;
  logic             cfgMemMode = 1'b1;
  logic             instValid = 1'b0, instIsLoad = 1'b0, instIsStore = 1'b0;
  logic [PC_W-1:0]  instPc = '0;
  logic             stall = 1'b0, flush = 1'b0;
  logic [PC_W-1:0]  flushPc = '0;
  logic             cutPulse;
  logic [PC_W-1:0]  cutStartPc;
  logic [LEN_W-1:0] cutLength;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  thread_cut_unit u_thread_cut_unit (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSkip(cfgSkip),
    .cfgMaxLen(cfgMaxLen), .cfgInterval(cfgInterval), .cfgMemMode(cfgMemMode),
    .instValid(instValid), .instPc(instPc), .instIsLoad(instIsLoad),
    .instIsStore(instIsStore), .stall(stall), .flush(flush), .flushPc(flushPc),
    .cutPulse(cutPulse), .cutStartPc(cutStartPc), .cutLength(cutLength)
  );

  // Vector: {valid, load, store, expCut, 4'h0, expLen}; PC = 'h100 + 4*index.
  // Run with skip 4, maximum 8, memory-slice mode.
  localparam int NVEC = 22;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h8000, 16'hC000, 16'hA000, 16'h8000, 16'hD004, 16'h8000, 16'h0000, 16'h8000,
    16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h9008, 16'hA000, 16'h8000,
    16'h8000, 16'hB004, 16'hC000, 16'hE000, 16'h8000, 16'hF004
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit ld, input bit st, input logic [PC_W-1:0] pc);
    @(negedge clk);
    instValid = v; instIsLoad = ld; instIsStore = st; instPc = pc;
    @(posedge clk); #1;
    instValid = 1'b0; instIsLoad = 1'b0; instIsStore = 1'b0;
  endtask

  task automatic expectCut(input bit expPulse, input logic [PC_W-1:0] expPc,
                           input int expLen, input string tag);
    check(cutPulse == expPulse, {tag, " pulse"}, cutPulse, expPulse);
    if (expPulse) begin
      check(cutStartPc == expPc, {tag, " pc"}, cutStartPc, expPc);
      check(cutLength == LEN_W'(expLen), {tag, " len"}, cutLength, expLen);
    end
  endtask

  task automatic configure(input int sk, input int mx, input int iv, input bit mm);
    @(negedge clk);
    cfgWe = 1'b1; cfgSkip = LEN_W'(sk); cfgMaxLen = LEN_W'(mx);
    cfgInterval = LEN_W'(iv); cfgMemMode = mm;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic doFlush(input logic [PC_W-1:0] pc, input string tag);
    @(negedge clk);
    flush = 1'b1; flushPc = pc;
    @(posedge clk); #1;
    flush = 1'b0;
    expectCut(1'b1, pc, 0, tag);
  endtask

  task automatic plains(input int n, input logic [PC_W-1:0] base, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0, base + PC_W'(4 * i));
      expectCut(1'b0, '0, 0, tag);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    check(cutPulse == 1'b0, "R1 reset pulse", cutPulse, 0);
    check(cutLength == '0, "R1 reset length", cutLength, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2/R3 defaults: skip 16.
    plains(15, 32'h1000, "R1 default fill");
    step(1'b1, 1'b1, 1'b0, 32'h2000);
    expectCut(1'b0, '0, 0, "R2 load inside default skip");
    step(1'b1, 1'b1, 1'b0, 32'h2004);
    expectCut(1'b1, 32'h2004, 16, "R3 default skip cut");
    // R4 default maximum 64.
    plains(63, 32'h3000, "R4 default max fill");
    step(1'b1, 1'b0, 1'b0, 32'h4000);
    expectCut(1'b1, 32'h4000, 64, "R4 default max cut");

    // Table walk, skip 4 max 8.
    configure(4, 8, 16, 1'b1);
    doFlush(32'h00FC, "R10 flush before table");
    for (int i = 0; i < NVEC; i++) begin
      logic [PC_W-1:0] pc;
      pc = 32'h100 + PC_W'(4 * i);
      step(VEC[i][15], VEC[i][14], VEC[i][13], pc);
      expectCut(VEC[i][12], pc, int'(VEC[i][7:0]),
                $sformatf("R2 R3 R4 R8 vector %0d", i));
    end

    // R5 clamp: max 6 below skip 10.
    configure(10, 6, 16, 1'b1);
    doFlush(32'h5000, "R10 flush");
    plains(10, 32'h5100, "R5 no cut below clamped max");
    step(1'b1, 1'b0, 1'b0, 32'h5200);
    expectCut(1'b1, 32'h5200, 10, "R5 clamped max cut");

    // R7 coincidence: skip 4, max 4, load at the limit.
    configure(4, 4, 16, 1'b1);
    doFlush(32'h6000, "R10 flush");
    plains(4, 32'h6100, "R7 fill");
    step(1'b1, 1'b1, 1'b0, 32'h6200);
    expectCut(1'b1, 32'h6200, 4, "R7 single boundary");
    step(1'b1, 1'b0, 1'b0, 32'h6204);
    expectCut(1'b0, '0, 0, "R7 no second pulse");

    // R6 fixed interval 5, loads only.
    configure(4, 8, 5, 1'b0);
    doFlush(32'h7000, "R10 flush");
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b1, 1'b0, 32'h7100 + PC_W'(4 * i));
      expectCut(1'b0, '0, 0, "R6 loads ignored");
    end
    step(1'b1, 1'b1, 1'b0, 32'h7200);
    expectCut(1'b1, 32'h7200, 5, "R6 interval cut");

    // R9 stall freezes.
    configure(4, 8, 16, 1'b1);
    doFlush(32'h8000, "R10 flush");
    plains(4, 32'h8100, "R9 fill");
    stall = 1'b1;
    step(1'b1, 1'b1, 1'b0, 32'h8200);
    expectCut(1'b0, '0, 0, "R9 stalled load");
    check(cutStartPc == 32'h8000, "R9 pc held", cutStartPc, 32'h8000);
    stall = 1'b0;
    step(1'b1, 1'b0, 1'b0, 32'h8204);
    expectCut(1'b0, '0, 0, "R9 count frozen");
    step(1'b1, 1'b1, 1'b0, 32'h8208);
    expectCut(1'b1, 32'h8208, 5, "R9 cut after stall");

    // R10 flush overrides stall.
    stall = 1'b1;
    doFlush(32'h9000, "R10 flush during stall");
    stall = 1'b0;

    // R11 write in same cycle as a cutting load uses old skip 4.
    plains(4, 32'h9100, "R11 fill");
    @(negedge clk);
    cfgWe = 1'b1; cfgSkip = 8'd8; cfgMaxLen = 8'd16; cfgInterval = 8'd16; cfgMemMode = 1'b1;
    instValid = 1'b1; instIsLoad = 1'b1; instPc = 32'h9200;
    @(posedge clk); #1;
    cfgWe = 1'b0; instValid = 1'b0; instIsLoad = 1'b0;
    expectCut(1'b1, 32'h9200, 4, "R11 old skip applies");
    plains(4, 32'h9300, "R11 fill");
    step(1'b1, 1'b1, 1'b0, 32'h9400);
    expectCut(1'b0, '0, 0, "R11 new skip 8 applies");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule